// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small 32-bit processor core that retires exactly one instruction on every rising clock edge. It runs nine instructions: word load, word store, add, subtract, bitwise and, bitwise or, signed set-on-less-than, branch when two registers are equal, and an absolute jump. It contains a program counter, a 32-entry general register file, an ALU with a zero flag, a 16-to-32-bit sign extender, and two private word arrays, one for instructions and one for data.

Control is decoded in two levels. A main decoder turns the 6-bit opcode into datapath selects, write enables and a 2-bit ALU class. A second decoder combines that class with the 6-bit function field of register-format instructions to produce a 4-bit ALU operation. Both decoders are purely combinational. The register file and data array are written on the clock edge and read combinationally, so a result becomes visible to the very next instruction.

A loading port fills either array while reset is held. The core then runs from address 0. Observation ports show the current PC and instruction, the register write being committed, the data store being committed, and one extra register read port for inspection.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, no register or data write is committed (`rf_we_o` = 0, `dm_we_o` = 0). One clock after `rst` is seen high, `pc_o` is 0 and every register reads zero.
- R2: Any instruction that is neither a branch nor a jump sets the next PC to the current PC + 4. Instructions are fetched from word index `pc[IM_AW+1:2]`.
- R3: Register-format instructions (opcode 0x00) write `rd` (bits 15:11). Function 0x20 adds, 0x22 subtracts, 0x24 ands, 0x25 ors, and 0x2A writes 1 if `rs` < `rt` as signed numbers and 0 otherwise.
- R4: A load (opcode 0x23) writes `rt` (bits 20:16) with the data word at byte address `rs` + sign-extended imm[15:0]. The word index is address bits [DM_AW+1:2].
- R5: A store (opcode 0x2B) writes `rt` to the data word at `rs` + sign-extended imm and writes no register.
- R6: A branch (opcode 0x04) sets the next PC to PC+4 + (sign-extended imm << 2) when `rs` equals `rt`. Otherwise the next PC is PC+4. It writes nothing.
- R7: A jump (opcode 0x02) sets the next PC to {PC+4[31:28], instr[25:0], 2'b00} and writes nothing.
- R8: A write aimed at register 0 leaves it unchanged, and register 0 always reads zero.
- R9: A register written by one instruction holds the new value for the next instruction. An instruction that reads and writes the same register reads the old value.
- R10: An opcode outside {0x00, 0x02, 0x04, 0x23, 0x2B} writes nothing and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write one word of the loading port this cycle |
| load_to_data | input | 1 | 1 selects the data array, 0 the instruction array |
| load_addr | input | LD_AW | Word index for the loaded word |
| load_data | input | 32 | Word to load |
| probe_addr | input | 5 | Register index for the inspection read port |
| probe_data | output | 32 | Combinational value of that register |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction being executed |
| rf_we_o | output | 1 | Register write committed at the next edge |
| rf_waddr_o | output | 5 | Destination register index |
| rf_wdata_o | output | 32 | Destination write value |
| dm_we_o | output | 1 | Data store committed at the next edge |
| dm_addr_o | output | 32 | Byte address computed by the ALU |
| dm_wdata_o | output | 32 | Store data |

## Verification
Within one cycle, a register read and a register write can hit the same register. This happens either because the instruction names the same register as source and destination, or because the previous instruction's write lands on the edge just before the read. The test program contains an add that doubles a register in place, loads that read words stored one instruction earlier, and a branch that compares a register written by the instruction before it. A behavioural instruction-level model in the bench predicts every commit and PC. The bench compares against that model on every clock, so the design reading a freshly written value too early or too late shows up as a mismatch.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;

    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_JUMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FUNCT = 2'b10
    } alu_cls_e;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111
    } alu_op_e;

    typedef struct packed {
        logic     dst_is_rd;
        logic     reg_we;
        logic     imm_operand;
        logic     load_to_reg;
        logic     mem_we;
        logic     branch;
        logic     jump;
        alu_cls_e alu_cls;
    } ctrl_t;

    typedef struct packed {
        logic [5:0]  opc;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [4:0]  rd;
        logic [4:0]  shamt;
        logic [5:0]  funct;
    } ifields_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] seq_pc,
                                                 input logic [25:0] idx);
        return {seq_pc[XLEN-1:XLEN-4], idx, 2'b00};
    endfunction

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
    import sc_pkg::*;
(
    input  logic [5:0] opc,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '0;
        ctrl.alu_cls = CLS_ADD;
        case (opc)
            OPC_REG: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_we    = 1'b1;
                ctrl.alu_cls   = CLS_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.imm_operand = 1'b1;
                ctrl.reg_we      = 1'b1;
                ctrl.load_to_reg = 1'b1;
            end
            OPC_STORE: begin
                ctrl.imm_operand = 1'b1;
                ctrl.mem_we      = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch  = 1'b1;
                ctrl.alu_cls = CLS_SUB;
            end
            OPC_JUMP: begin
                ctrl.jump = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/sc_alu_ctrl.sv
module sc_alu_ctrl
    import sc_pkg::*;
(
    input  alu_cls_e   cls,
    input  logic [5:0] funct,
    output alu_op_e    op
);
    always_comb begin
        case (cls)
            CLS_ADD: op = ALU_ADD;
            CLS_SUB: op = ALU_SUB;
            default: begin
                case (funct)
                    FN_ADD:  op = ALU_ADD;
                    FN_SUB:  op = ALU_SUB;
                    FN_AND:  op = ALU_AND;
                    FN_OR:   op = ALU_OR;
                    FN_SLT:  op = ALU_SLT;
                    default: op = ALU_ADD;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W   = 32,
    parameter int AW  = 5,
    parameter int NRD = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [W-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][W-1:0]   rdata
);
    localparam int NREG = 1 << AW;

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = (raddr[g] == '0) ? '0 : regs[raddr[g]];
    end
endmodule

// File: rtl/sc_ram.sv
module sc_ram #(
    parameter int W  = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IM_AW = 6,
    parameter int DM_AW = 6,
    parameter int LD_AW = (IM_AW > DM_AW) ? IM_AW : DM_AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic             load_to_data,
    input  logic [LD_AW-1:0] load_addr,
    input  logic [31:0]      load_data,
    input  logic [4:0]       probe_addr,
    output logic [31:0]      probe_data,
    output logic [31:0]      pc_o,
    output logic [31:0]      instr_o,
    output logic             rf_we_o,
    output logic [4:0]       rf_waddr_o,
    output logic [31:0]      rf_wdata_o,
    output logic             dm_we_o,
    output logic [31:0]      dm_addr_o,
    output logic [31:0]      dm_wdata_o
);
    localparam int NRD = 3;

    logic [XLEN-1:0] pc_q, pc_seq, pc_br, pc_next;
    logic [XLEN-1:0] instr;
    ifields_t        fld;
    ctrl_t           ctrl;
    alu_op_e         alu_op;
    logic [XLEN-1:0] imm_ext, alu_b, alu_y;
    logic            alu_zero;
    logic [XLEN-1:0] rs_val, rt_val, wb_data, dm_rdata;
    logic [REG_AW-1:0] wb_addr;
    logic            rf_we, st_we;
    logic [NRD-1:0][REG_AW-1:0] rf_raddr;
    logic [NRD-1:0][XLEN-1:0]   rf_rdata;
    logic            im_we, dm_we;
    logic [DM_AW-1:0] dm_waddr;
    logic [XLEN-1:0] dm_wdata;

    // fetch
    sc_ram #(.W(XLEN), .AW(IM_AW)) u_imem (
        .clk   (clk),
        .we    (im_we),
        .waddr (load_addr[IM_AW-1:0]),
        .wdata (load_data),
        .raddr (pc_q[IM_AW+1:2]),
        .rdata (instr)
    );
    assign im_we = load_en && !load_to_data;
    assign fld   = ifields_t'(instr);

    // decode
    sc_main_dec u_dec (
        .opc  (fld.opc),
        .ctrl (ctrl)
    );

    sc_alu_ctrl u_aluctl (
        .cls   (ctrl.alu_cls),
        .funct (fld.funct),
        .op    (alu_op)
    );

    // operands
    assign rf_raddr[0] = fld.rs;
    assign rf_raddr[1] = fld.rt;
    assign rf_raddr[2] = probe_addr;

    sc_regfile #(.W(XLEN), .AW(REG_AW), .NRD(NRD)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (wb_addr),
        .wdata (wb_data),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );
    assign rs_val     = rf_rdata[0];
    assign rt_val     = rf_rdata[1];
    assign probe_data = rf_rdata[2];

    assign imm_ext = sext16(instr[15:0]);
    assign alu_b   = ctrl.imm_operand ? imm_ext : rt_val;

    // execute
    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data memory: loading port has priority over stores
    assign st_we = ctrl.mem_we && !rst;
    always_comb begin
        if (load_en && load_to_data) begin
            dm_we    = 1'b1;
            dm_waddr = load_addr[DM_AW-1:0];
            dm_wdata = load_data;
        end else begin
            dm_we    = st_we;
            dm_waddr = alu_y[DM_AW+1:2];
            dm_wdata = rt_val;
        end
    end

    sc_ram #(.W(XLEN), .AW(DM_AW)) u_dmem (
        .clk   (clk),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr (alu_y[DM_AW+1:2]),
        .rdata (dm_rdata)
    );

    // write back
    assign rf_we   = ctrl.reg_we && !rst;
    assign wb_addr = ctrl.dst_is_rd ? fld.rd : fld.rt;
    assign wb_data = ctrl.load_to_reg ? dm_rdata : alu_y;

    // next PC
    assign pc_seq = pc_q + 32'd4;
    assign pc_br  = pc_seq + (imm_ext << 2);
    always_comb begin
        if (ctrl.jump)                      pc_next = jump_dest(pc_seq, instr[25:0]);
        else if (ctrl.branch && alu_zero)   pc_next = pc_br;
        else                                pc_next = pc_seq;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    // observation
    assign pc_o       = pc_q;
    assign instr_o    = instr;
    assign rf_we_o    = rf_we;
    assign rf_waddr_o = wb_addr;
    assign rf_wdata_o = wb_data;
    assign dm_we_o    = st_we;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic        rf_we,
    input logic        dm_we,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic [4:0]  probe_addr,
    input logic [31:0] probe_data
);
    logic [5:0]  opc;
    logic        known;
    logic [31:0] seq, br_dest, j_dest;

    assign opc     = instr[31:26];
    assign known   = (opc == OPC_REG) || (opc == OPC_JUMP) || (opc == OPC_BEQ) ||
                     (opc == OPC_LOAD) || (opc == OPC_STORE);
    assign seq     = pc + 32'd4;
    assign br_dest = seq + {{14{instr[15]}}, instr[15:0], 2'b00};
    assign j_dest  = {seq[31:28], instr[25:0], 2'b00};

    // R1
    a_r1_reset_pc: assert property (@(posedge clk) rst |=> (pc == 32'd0));
    a_r1_no_commit: assert property (@(posedge clk) rst |-> (!rf_we && !dm_we));

    // R2 and R6 not-taken
    a_r2_seq_pc: assert property (@(posedge clk) disable iff (rst)
        ((opc != OPC_JUMP && opc != OPC_BEQ) || (opc == OPC_BEQ && rs_val != rt_val))
        |=> (pc == $past(seq)));

    // R6 taken
    a_r6_branch_taken: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_BEQ && rs_val == rt_val) |=> (pc == $past(br_dest)));

    // R7
    a_r7_jump_dest: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_JUMP) |=> (pc == $past(j_dest)));

    // R5
    a_r5_store_no_reg: assert property (@(posedge clk) disable iff (rst)
        dm_we |-> !rf_we);

    // R10
    a_r10_undef_quiet: assert property (@(posedge clk) disable iff (rst)
        !known |-> (!rf_we && !dm_we));

    // R8
    a_r8_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (probe_addr == 5'd0) |-> (probe_data == 32'd0));
endmodule

bind sc_core sc_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc         (pc_o),
    .instr      (instr_o),
    .rf_we      (rf_we_o),
    .dm_we      (dm_we_o),
    .rs_val     (rs_val),
    .rt_val     (rt_val),
    .probe_addr (probe_addr),
    .probe_data (probe_data)
);

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic        load_to_data = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [4:0]  probe_addr = '0;
    logic [31:0] probe_data, pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic        rf_we_o, dm_we_o;
    logic [4:0]  rf_waddr_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    sc_core u_dut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_to_data(load_to_data),
        .load_addr(load_addr), .load_data(load_data), .probe_addr(probe_addr),
        .probe_data(probe_data), .pc_o(pc_o), .instr_o(instr_o), .rf_we_o(rf_we_o),
        .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .dm_we_o(dm_we_o),
        .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    // reference state
    logic [31:0] m_rf [32];
    logic [31:0] m_dm [64];
    logic [31:0] m_im [64];
    logic [31:0] m_pc;
    string       pc_tag;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    // one step of the instruction-level model, compared with the ports
    task automatic model_step();
        logic [31:0] ins, a, b, imm, nxt, wd, addr;
        logic [5:0]  op, fn;
        logic [4:0]  wa;
        logic        rwe, dwe;
        string       tag;
        ins = m_im[m_pc[7:2]];
        op  = ins[31:26];
        fn  = ins[5:0];
        a   = m_rf[ins[25:21]];
        b   = m_rf[ins[20:16]];
        imm = {{16{ins[15]}}, ins[15:0]};
        addr = a + imm;
        nxt = m_pc + 4;
        rwe = 1'b0; dwe = 1'b0; wa = '0; wd = '0;
        case (op)
            6'h00: begin
                tag = "R3/R9"; rwe = 1'b1; wa = ins[15:11];
                case (fn)
                    6'h20: wd = a + b;
                    6'h22: wd = a - b;
                    6'h24: wd = a & b;
                    6'h25: wd = a | b;
                    6'h2A: wd = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: wd = a + b;
                endcase
            end
            6'h23: begin tag = "R4"; rwe = 1'b1; wa = ins[20:16]; wd = m_dm[addr[7:2]]; end
            6'h2B: begin tag = "R5"; dwe = 1'b1; end
            6'h04: begin tag = "R6"; if (a == b) nxt = m_pc + 4 + (imm << 2); end
            6'h02: begin tag = "R7"; nxt = {m_pc[31:28] , ins[25:0], 2'b00};
                         nxt[31:28] = (m_pc + 32'd4) >> 28; end
            default: tag = "R10";
        endcase
        chk(pc_tag, "pc", pc_o, m_pc);
        chk(tag, "rf_we", {31'd0, rf_we_o}, {31'd0, rwe});
        if (rwe) begin
            chk(tag, "rf_waddr", {27'd0, rf_waddr_o}, {27'd0, wa});
            chk(tag, "rf_wdata", rf_wdata_o, wd);
        end
        chk(tag, "dm_we", {31'd0, dm_we_o}, {31'd0, dwe});
        if (dwe) begin
            chk(tag, "dm_addr", dm_addr_o, addr);
            chk(tag, "dm_wdata", dm_wdata_o, b);
        end
        if (rwe && wa != 5'd0) m_rf[wa] = wd;
        if (dwe) m_dm[addr[7:2]] = b;
        pc_tag = (op == 6'h04) ? "R6" : (op == 6'h02) ? "R7" : "R2";
        m_pc = nxt;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            tests++; fails++;
            $display("FAIL R1 watchdog expired actual=%0d expected<=5000", cycles);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin m_im[i] = 32'd0; m_dm[i] = 32'd0; end
        for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
        m_dm[0] = 32'd5;
        m_dm[1] = 32'd12;
        m_dm[2] = 32'hFFFF_FFFD;
        m_dm[3] = 32'h0F0F_00FF;
        m_dm[4] = 32'h8000_0000;

        m_im[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'd0);
        m_im[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'd4);
        m_im[2]  = enc_i(6'h23, 5'd0, 5'd3, 16'd8);
        m_im[3]  = enc_i(6'h23, 5'd0, 5'd4, 16'd12);
        m_im[4]  = enc_r(5'd1, 5'd2, 5'd5, 6'h20);
        m_im[5]  = enc_r(5'd1, 5'd2, 5'd6, 6'h22);
        m_im[6]  = enc_r(5'd4, 5'd2, 5'd7, 6'h24);
        m_im[7]  = enc_r(5'd4, 5'd1, 5'd8, 6'h25);
        m_im[8]  = enc_r(5'd3, 5'd1, 5'd9, 6'h2A);
        m_im[9]  = enc_r(5'd1, 5'd3, 5'd10, 6'h2A);
        m_im[10] = enc_r(5'd1, 5'd2, 5'd0, 6'h20);
        m_im[11] = enc_r(5'd1, 5'd1, 5'd1, 6'h20);
        m_im[12] = enc_i(6'h2B, 5'd0, 5'd5, 16'd20);
        m_im[13] = enc_i(6'h23, 5'd0, 5'd11, 16'd20);
        m_im[14] = enc_i(6'h2B, 5'd2, 5'd6, 16'hFFFC);
        m_im[15] = enc_i(6'h23, 5'd0, 5'd12, 16'd8);
        m_im[16] = enc_i(6'h04, 5'd1, 5'd2, 16'd5);
        m_im[17] = enc_r(5'd2, 5'd1, 5'd13, 6'h22);
        m_im[18] = enc_i(6'h04, 5'd13, 5'd13, 16'd2);
        m_im[19] = enc_r(5'd1, 5'd1, 5'd14, 6'h20);
        m_im[20] = enc_r(5'd1, 5'd1, 5'd14, 6'h20);
        m_im[21] = 32'hFC00_0000;
        m_im[22] = {6'h02, 26'd25};
        m_im[23] = enc_r(5'd1, 5'd2, 5'd15, 6'h20);
        m_im[24] = enc_r(5'd1, 5'd2, 5'd15, 6'h20);
        m_im[25] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);

        // load both arrays under reset
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            load_en = 1'b1;
            load_to_data = (i >= 64);
            load_addr = 6'(i % 64);
            load_data = (i >= 64) ? m_dm[i - 64] : m_im[i];
        end
        @(negedge clk);
        load_en = 1'b0;
        #1;
        chk("R1", "pc in reset", pc_o, 32'd0);
        chk("R1", "rf_we in reset", {31'd0, rf_we_o}, 32'd0);
        chk("R1", "dm_we in reset", {31'd0, dm_we_o}, 32'd0);
        probe_addr = 5'd7; #1;
        chk("R1", "r7 after reset", probe_data, 32'd0);
        probe_addr = 5'd0;

        m_pc = 32'd0;
        pc_tag = "R1";
        rst = 1'b0;
        #1 model_step();
        for (int n = 0; n < 44; n++) begin
            @(negedge clk);
            #1 model_step();
        end

        // final register contents
        for (int r = 0; r < 32; r++) begin
            probe_addr = 5'(r); #1;
            chk((r == 0) ? "R8" : "R9", $sformatf("reg %0d", r), probe_data, m_rf[r]);
        end
        probe_addr = 5'd0; #1;
        chk("R8", "r0 after write to r0", probe_data, 32'd0);
        probe_addr = 5'd1; #1;
        chk("R9", "in-place double", probe_data, 32'd10);
        probe_addr = 5'd12; #1;
        chk("R5", "negative-offset store then load", probe_data, 32'hFFFF_FFF9);

        // reset in the middle of the run
        @(negedge clk);
        rst = 1'b1; #1;
        chk("R1", "rf_we with rst", {31'd0, rf_we_o}, 32'd0);
        @(negedge clk); #1;
        chk("R1", "pc after rst", pc_o, 32'd0);
        probe_addr = 5'd5; #1;
        chk("R1", "r5 cleared", probe_data, 32'd0);
        finish_run();
    end
endmodule